// File: doc/BRIEF.md
# Serial Control Register Slave

This block is the control-register endpoint of a mixed-signal front end. A host reaches it over a three-wire serial link made of an active-low select, a serial clock and one shared data line. The block samples the three pins with its own system clock and synchronizes them. It decodes 16-bit frames and keeps eleven 8-bit control registers. Each configuration field of those registers is presented as a dedicated output. During a read the block turns the shared data line around: it raises an output-enable and shifts the addressed register out on falling serial-clock edges. The pad that merges the input, output and enable is outside the block.

A frame is sent most significant bit first. It holds a direction bit (0 = write, 1 = read), three reserved bits that must be zero, a 4-bit address and 8 data bits. A write is held back until the select line rises, and it is applied only if the frame reached 16 rising clock edges. A frame state machine controls the sequence through these states:

- IDLE: the select line is high.
- HEADER: the first 8 bits are arriving.
- WRITE_DATA: the data byte of a write is arriving.
- HOLD: a complete write is waiting for the select line to rise.
- READ_DATA: the line is being driven.
- VOID: the header was malformed and the rest of the frame is ignored.

The transitions are:

- **open**: IDLE to HEADER when the select line is seen low.
- **decode**: at the 8th rising edge, HEADER goes to READ_DATA, WRITE_DATA or VOID.
- **complete**: WRITE_DATA to HOLD at the 16th rising edge.
- **close**: any state to IDLE when the select line is high. Leaving HOLD this way applies the write.

Top module: `ctl_serial_regs`

## Requirements
- R1: After reset, and whenever the select line is high, the data output-enable is low. After reset, all eleven registers and every field output are 0.
- R2: While the select line is low, the data line is captured on each rising serial-clock edge. A frame whose bit 1 is 0 writes the register addressed by bits 5-8 (MSB first) with bits 9-16 (MSB first).
- R3: A write is applied only when the select line rises after at least 16 rising clock edges. A frame closed after fewer edges changes no register.
- R4: Rising edges beyond the 16th do not alter the frame: the first 16 bits alone decide the address and the data.
- R5: A frame whose bit 1 is 1 is a read. The output-enable stays low during the 8 header bits. From the falling clock edge after the 8th rising edge, the addressed register is driven MSB first, one bit per falling edge.
- R6: Falling edges after the 8th data bit of a read drive 0. The output-enable drops once the select line goes high.
- R7: Writes to addresses 0xB-0xF change no register. Reads of those addresses return 0x00.
- R8: Undefined bits are stored and read as 0. These are: bit 3 of register 0; bits 7:6 of registers 1-3; bits 7, 6, 3 and 1 of register 7; bits 7:3 of registers 8-0xA.
- R9: The fields map as follows.
  - Register 0: bit 7 is `pwr_en`, bits 6/5/4 are `sh_boost[0]/[1]/[2]`, bit 2 is `vref_internal`, bit 1 is `vref_high`, bit 0 is `one_channel`.
  - Registers 1-3: bits 5:0 give `ofs_code` for channels 0-2 (channel c at bits c*6+5:c*6).
  - Registers 4-6: give `dgain_code` for channels 0-2 (channel c at bits c*8+7:c*8).
  - Register 7: bit 5 is `cascade_en`, bit 4 is `cascade_id`, bit 2 is `weak_drive`, bit 0 is `gray_en`.
  - Registers 8-0xA: bits 2:0 give `led_level` for channels 0-2 (channel c at bits c*3+2:c*3).
- R10: All frame state is cleared while the select line is high. A frame abandoned part way leaves no trace in the next frame.
- R11: A frame whose reserved bits 2-4 are not all 0 is void: it writes nothing and never drives the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sif_cs_n | input | 1 | Active-low frame select |
| sif_sck | input | 1 | Serial clock |
| sif_sdi | input | 1 | Data line, input side |
| sif_sdo | output | 1 | Data line, output side |
| sif_sdo_oe | output | 1 | Output-enable for the data line |
| pwr_en | output | 1 | Power enable field |
| sh_boost | output | 3 | Per-channel sample stage boost |
| vref_internal | output | 1 | Use internal sensor reference |
| vref_high | output | 1 | Higher internal reference level |
| one_channel | output | 1 | Single-channel input mode |
| ofs_code | output | 18 | Per-channel 6-bit offset codes |
| dgain_code | output | 24 | Per-channel 8-bit digital gain codes |
| cascade_en | output | 1 | Shared-bus output mode |
| cascade_id | output | 1 | Device slot on the shared bus |
| weak_drive | output | 1 | Reduced output drive |
| gray_en | output | 1 | Gray-coded output format |
| led_level | output | 9 | Per-channel 3-bit LED current level |

## Verification
The bench builds the block with two synchronizer stages and holds each serial-clock phase for six system clocks. This leaves time for the pin-to-edge latency before every sample, so each rising and falling edge is seen exactly once. With these values the bench can sample the turned-around line just before each rising edge, as a host would. It also reaches the counting corners: frames of 10, 15, 16 and 20 edges, an abandoned frame, and the trailing-zero bits of a read.

// File: rtl/sif_pkg.sv
package sif_pkg;

    localparam int NCH        = 3;
    localparam int DW         = 8;
    localparam int AW         = 4;
    localparam int NREG       = 11;
    localparam int HDR_BITS   = 8;
    localparam int FRAME_BITS = HDR_BITS + DW;
    localparam int CNT_MAX    = FRAME_BITS + 1;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);
    localparam int OFS_W      = 6;
    localparam int LED_W      = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_WDATA,
        ST_HOLD,
        ST_RDATA,
        ST_VOID
    } sif_state_e;

    // Defined bits of each register; all other bits are stored as 0.
    function automatic logic [DW-1:0] reg_mask(input logic [AW-1:0] a);
        logic [DW-1:0] m;
        case (a)
            4'h0:                m = 8'hF7;
            4'h1, 4'h2, 4'h3:    m = 8'h3F;
            4'h4, 4'h5, 4'h6:    m = 8'hFF;
            4'h7:                m = 8'h35;
            4'h8, 4'h9, 4'hA:    m = 8'h07;
            default:             m = 8'h00;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/sif_sync.sv
module sif_sync #(
    parameter int          STAGES  = 2,
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[b]}};
            end else begin
                chain <= {chain[STAGES-2:0], din[b]};
            end
        end

        assign lvl[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/sif_frame.sv
module sif_frame
    import sif_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_lvl,
    input  logic          sck_lvl,
    input  logic          sdi_lvl,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] addr,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic          sdo,
    output logic          sdo_oe
);

    sif_state_e       state, state_nx;
    logic             cs_q, sck_q;
    logic             cs_rise, sck_rise, sck_fall;
    logic [CNT_W-1:0] bit_cnt;
    logic [DW-1:0]    hdr_sh;
    logic [DW-1:0]    dat_sh;
    logic [DW-1:0]    rd_sh;
    logic             rd_live;
    logic             hdr_last;

    assign cs_rise  = cs_lvl & ~cs_q;
    assign sck_rise = sck_lvl & ~sck_q;
    assign sck_fall = ~sck_lvl & sck_q;
    assign hdr_last = sck_rise && (bit_cnt == CNT_W'(HDR_BITS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            sck_q <= 1'b0;
        end else begin
            cs_q  <= cs_lvl;
            sck_q <= sck_lvl;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (cs_lvl) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_HDR;
                ST_HDR: begin
                    if (hdr_last) begin
                        if (hdr_sh[5:3] != 3'b000) begin
                            state_nx = ST_VOID;
                        end else if (hdr_sh[6]) begin
                            state_nx = ST_RDATA;
                        end else begin
                            state_nx = ST_WDATA;
                        end
                    end
                end
                ST_WDATA: begin
                    if (sck_rise && bit_cnt == CNT_W'(FRAME_BITS - 1)) begin
                        state_nx = ST_HOLD;
                    end
                end
                ST_HOLD:  state_nx = ST_HOLD;
                ST_RDATA: state_nx = ST_RDATA;
                ST_VOID:  state_nx = ST_VOID;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // Frame datapath: counter, shifters, read serializer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            hdr_sh  <= '0;
            dat_sh  <= '0;
            rd_sh   <= '0;
            rd_live <= 1'b0;
        end else if (cs_lvl) begin
            bit_cnt <= '0;
            hdr_sh  <= '0;
            dat_sh  <= '0;
            rd_sh   <= '0;
            rd_live <= 1'b0;
        end else begin
            if (sck_rise) begin
                if (bit_cnt < CNT_W'(HDR_BITS)) begin
                    hdr_sh <= {hdr_sh[DW-2:0], sdi_lvl};
                end else if (bit_cnt < CNT_W'(FRAME_BITS)) begin
                    dat_sh <= {dat_sh[DW-2:0], sdi_lvl};
                end
                if (bit_cnt != CNT_W'(CNT_MAX)) begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
            if (sck_fall && state == ST_RDATA) begin
                if (!rd_live) begin
                    rd_sh   <= rd_data;
                    rd_live <= 1'b1;
                end else begin
                    rd_sh <= {rd_sh[DW-2:0], 1'b0};
                end
            end
        end
    end

    // Outputs
    always_comb begin
        addr    = hdr_sh[AW-1:0];
        wr_data = dat_sh;
        wr_en   = cs_rise && (state == ST_HOLD) && !hdr_sh[DW-1];
        sdo_oe  = (state == ST_RDATA) && rd_live;
        sdo     = sdo_oe & rd_sh[DW-1];
    end

    // R3
    commit_after_sixteen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (bit_cnt >= CNT_W'(FRAME_BITS)));

    // R4
    extra_edges_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_rise && !cs_lvl && bit_cnt >= CNT_W'(FRAME_BITS)) |=> ($stable(hdr_sh) && $stable(dat_sh)));

    // R5
    drive_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> ($past(sck_fall) && bit_cnt == CNT_W'(HDR_BITS)));

    // R6
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lvl |=> !sdo_oe);

endmodule

// File: rtl/sif_regfile.sv
module sif_regfile
    import sif_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wr_data,
    output logic [DW-1:0]        rd_data,
    output logic                 pwr_en,
    output logic [NCH-1:0]       sh_boost,
    output logic                 vref_internal,
    output logic                 vref_high,
    output logic                 one_channel,
    output logic [NCH*OFS_W-1:0] ofs_code,
    output logic [NCH*DW-1:0]    dgain_code,
    output logic                 cascade_en,
    output logic                 cascade_id,
    output logic                 weak_drive,
    output logic                 gray_en,
    output logic [NCH*LED_W-1:0] led_level
);

    localparam int OFS_BASE  = 1;
    localparam int GAIN_BASE = OFS_BASE + NCH;
    localparam int CTL2_ADDR = GAIN_BASE + NCH;
    localparam int LED_BASE  = CTL2_ADDR + 1;

    logic [DW-1:0]      regs [NREG];
    logic [NREG*DW-1:0] reg_flat;
    logic [NREG*DW-1:0] def_flat;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (wr_en && addr == AW'(i)) begin
                regs[i] <= wr_data & reg_mask(AW'(i));
            end
        end
        assign reg_flat[i*DW +: DW] = regs[i];
        assign def_flat[i*DW +: DW] = reg_mask(AW'(i));
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (addr == AW'(i)) begin
                rd_data = regs[i];
            end
        end
    end

    assign pwr_en        = regs[0][7];
    assign vref_internal = regs[0][2];
    assign vref_high     = regs[0][1];
    assign one_channel   = regs[0][0];
    assign cascade_en    = regs[CTL2_ADDR][5];
    assign cascade_id    = regs[CTL2_ADDR][4];
    assign weak_drive    = regs[CTL2_ADDR][2];
    assign gray_en       = regs[CTL2_ADDR][0];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign sh_boost[c]                = regs[0][6-c];
        assign ofs_code[c*OFS_W +: OFS_W] = regs[OFS_BASE + c][OFS_W-1:0];
        assign dgain_code[c*DW +: DW]     = regs[GAIN_BASE + c];
        assign led_level[c*LED_W +: LED_W] = regs[LED_BASE + c][LED_W-1:0];
    end

    // R7
    oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr >= AW'(NREG)) |=> $stable(reg_flat));

    // R8
    undefined_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_flat & ~def_flat) == '0);

endmodule

// File: rtl/ctl_serial_regs.sv
module ctl_serial_regs
    import sif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sif_cs_n,
    input  logic                 sif_sck,
    input  logic                 sif_sdi,
    output logic                 sif_sdo,
    output logic                 sif_sdo_oe,
    output logic                 pwr_en,
    output logic [NCH-1:0]       sh_boost,
    output logic                 vref_internal,
    output logic                 vref_high,
    output logic                 one_channel,
    output logic [NCH*OFS_W-1:0] ofs_code,
    output logic [NCH*DW-1:0]    dgain_code,
    output logic                 cascade_en,
    output logic                 cascade_id,
    output logic                 weak_drive,
    output logic                 gray_en,
    output logic [NCH*LED_W-1:0] led_level
);

    logic [2:0]    pin_lvl;
    logic [AW-1:0] addr;
    logic          wr_en;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_data;

    sif_sync #(
        .STAGES  (SYNC_STAGES),
        .W       (3),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sif_sdi, sif_sck, sif_cs_n}),
        .lvl   (pin_lvl)
    );

    sif_frame u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_lvl  (pin_lvl[0]),
        .sck_lvl (pin_lvl[1]),
        .sdi_lvl (pin_lvl[2]),
        .rd_data (rd_data),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .sdo     (sif_sdo),
        .sdo_oe  (sif_sdo_oe)
    );

    sif_regfile u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .addr          (addr),
        .wr_data       (wr_data),
        .rd_data       (rd_data),
        .pwr_en        (pwr_en),
        .sh_boost      (sh_boost),
        .vref_internal (vref_internal),
        .vref_high     (vref_high),
        .one_channel   (one_channel),
        .ofs_code      (ofs_code),
        .dgain_code    (dgain_code),
        .cascade_en    (cascade_en),
        .cascade_id    (cascade_id),
        .weak_drive    (weak_drive),
        .gray_en       (gray_en),
        .led_level     (led_level)
    );

endmodule

// File: tb/test_ctl_serial_regs.sv
module test_ctl_serial_regs;

    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic sdi = 1'b0;
    logic sdo, sdo_oe;
    logic pwr_en, vref_internal, vref_high, one_channel;
    logic cascade_en, cascade_id, weak_drive, gray_en;
    logic [2:0]  sh_boost;
    logic [17:0] ofs_code;
    logic [23:0] dgain_code;
    logic [8:0]  led_level;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ctl_serial_regs #(.SYNC_STAGES(2)) i_ctl_serial_regs (
        .clk(clk), .rst_n(rst_n), .sif_cs_n(cs_n), .sif_sck(sck), .sif_sdi(sdi),
        .sif_sdo(sdo), .sif_sdo_oe(sdo_oe), .pwr_en(pwr_en), .sh_boost(sh_boost),
        .vref_internal(vref_internal), .vref_high(vref_high), .one_channel(one_channel),
        .ofs_code(ofs_code), .dgain_code(dgain_code), .cascade_en(cascade_en),
        .cascade_id(cascade_id), .weak_drive(weak_drive), .gray_en(gray_en),
        .led_level(led_level)
    );

    // {address, write data, expected read-back}
    localparam logic [19:0] VEC [8] = '{
        20'h0FFF7, 20'h1FF3F, 20'h22A2A, 20'h4A5A5,
        20'h65A5A, 20'h7FF35, 20'hAFF07, 20'hBFF00
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drives one frame of nbits edges; returns captured line bits and oe mismatches.
    task automatic frame(input logic [15:0] word, input int nbits, input bit is_rd,
                         output logic [23:0] cap, output int oe_bad);
        cap = '0;
        oe_bad = 0;
        @(negedge clk);
        cs_n = 1'b0;
        wait_n(H);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 16) ? word[15-i] : 1'b1;
            wait_n(H);
            cap[i] = sdo;
            if (sdo_oe !== (is_rd && i >= 8)) oe_bad++;
            sck = 1'b1;
            wait_n(H);
            sck = 1'b0;
        end
        wait_n(H);
        cs_n = 1'b1;
        wait_n(8);
        if (sdo_oe !== 1'b0) oe_bad++;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input int nbits);
        logic [23:0] cap;
        int bad;
        frame({4'b0000, a, d}, nbits, 1'b0, cap, bad);
        chk("R1 R5 oe low in write", 32'(bad), 32'd0);
    endtask

    task automatic rd(input logic [3:0] a, input int nbits, output logic [7:0] v,
                      output logic [23:0] cap);
        int bad;
        frame({4'b1000, a, 8'h00}, nbits, 1'b1, cap, bad);
        for (int k = 0; k < 8; k++) v[7-k] = cap[8+k];
        chk("R5 R6 oe timing in read", 32'(bad), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  v;
        logic [23:0] cap;
        int          bad;

        wait_n(5);
        rst_n = 1'b1;
        wait_n(5);

        // R1 reset state
        chk("R1 oe after reset", 32'(sdo_oe), 32'd0);
        chk("R1 fields after reset",
            32'({pwr_en, sh_boost, vref_internal, vref_high, one_channel, cascade_en,
                 cascade_id, weak_drive, gray_en}), 32'd0);
        chk("R1 vectors after reset", {ofs_code, led_level} == '0 && dgain_code == '0 ? 32'd1 : 32'd0, 32'd1);
        rd(4'h4, 16, v, cap);
        chk("R1 reg4 reads 0", 32'(v), 32'h00);

        // Table: R2 write, R7 out of range, R8 undefined bits
        for (int n = 0; n < 8; n++) begin
            wr(VEC[n][19:16], VEC[n][15:8], 16);
            rd(VEC[n][19:16], 16, v, cap);
            chk($sformatf("R2 R7 R8 vector %0d", n), 32'(v), 32'(VEC[n][7:0]));
        end
        wr(4'hF, 8'hAA, 16);
        rd(4'hF, 16, v, cap);
        chk("R7 read addr F", 32'(v), 32'h00);

        // R9 field mapping
        chk("R9 reg0 fields", 32'({pwr_en, sh_boost, vref_internal, vref_high, one_channel}), 32'h7F);
        chk("R9 ofs_code", 32'(ofs_code), 32'h00ABF);
        chk("R9 dgain_code", 32'(dgain_code), 32'h5A00A5);
        chk("R9 reg7 fields", 32'({cascade_en, cascade_id, weak_drive, gray_en}), 32'hF);
        chk("R9 led_level", 32'(led_level), 32'h1C0);

        // R3 short frame
        wr(4'h5, 8'h77, 15);
        rd(4'h5, 16, v, cap);
        chk("R3 15-edge write ignored", 32'(v), 32'h00);
        chk("R3 dgain unchanged", 32'(dgain_code), 32'h5A00A5);

        // R4 long frame
        wr(4'h8, 8'h03, 20);
        rd(4'h8, 16, v, cap);
        chk("R4 first 16 bits count", 32'(v), 32'h03);

        // R6 trailing zeros
        rd(4'h2, 20, v, cap);
        chk("R6 read value", 32'(v), 32'h2A);
        chk("R6 trailing zeros", 32'(cap[19:16]), 32'h0);

        // R10 abandoned frame then a clean frame
        wr(4'h9, 8'hFF, 10);
        rd(4'h9, 16, v, cap);
        chk("R3 R10 aborted write", 32'(v), 32'h00);
        wr(4'h9, 8'h02, 16);
        rd(4'h9, 16, v, cap);
        chk("R10 clean frame after abort", 32'(v), 32'h02);

        // R11 nonzero reserved bits
        frame({4'b0010, 4'h4, 8'h11}, 16, 1'b0, cap, bad);
        chk("R11 void write no oe", 32'(bad), 32'd0);
        rd(4'h4, 16, v, cap);
        chk("R11 void write ignored", 32'(v), 32'hA5);
        frame({4'b1100, 4'h4, 8'h00}, 16, 1'b0, cap, bad);
        chk("R11 void read never drives", 32'(bad), 32'd0);

        // R1 reset clears
        @(negedge clk);
        rst_n = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(5);
        chk("R1 fields after second reset",
            32'({pwr_en, sh_boost, gray_en, cascade_en}), 32'd0);
        rd(4'h4, 16, v, cap);
        chk("R1 reg4 cleared", 32'(v), 32'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule